// File: doc/BRIEF.md
# Two-Channel External Interrupt Sense Controller

This block turns two external input pins into interrupt requests for a processor. Each channel samples its pin through a synchronizer and is set to one of four sense modes: low level, any change, falling edge or rising edge. In the three edge modes a qualifying transition sets a sticky per-channel flag. The channel then requests service while its flag, its mask bit and the global interrupt enable are all one. The flag clears when the processor acknowledges that channel, or when software writes a one to its bit in the flag register.

In low-level mode the sticky flag is bypassed. The flag reads as zero, and the request follows the synchronized pin directly for as long as the pin is low and the channel is enabled. Software reaches the mode, mask and flag registers through a small synchronous write port and a combinational read port.

Top module: `eint_sense_top`

## Requirements
- R1: After reset, every sense mode is 00, every mask bit and every flag is 0, and both request lines are low.
- R2: Address 0 holds the sense modes, with channel 0 in bits [1:0] and channel 1 in bits [3:2]. Address 1 holds the mask, one bit per channel at the channel's index. Address 2 holds the flags in the same bit positions. Address 3 reads as zero. Writes to addresses 0 and 1 are read back unchanged.
- R3: The sense code 01 sets the flag on either transition, 10 sets it only on a high-to-low transition, and 11 sets it only on a low-to-high transition. The flag does not change without such a transition or a clear.
- R4: In the edge modes, a channel's request is high exactly when its flag, its mask bit and the global enable are all one.
- R5: Writing a one to a flag bit at address 2 clears that flag. Writing a zero leaves it as it is.
- R6: A one on a channel's acknowledge input clears that channel's flag on the next clock edge.
- R7: With sense code 00 the flag reads as zero. The request is high while the synchronized pin is low and the mask bit and global enable are one.
- R8: A pin change is seen by the flag on the third rising clock edge after the pin changes. Any level held for two or more cycles is detected.
- R9: If a clear (write-one or acknowledge) and a qualifying transition fall in the same cycle, the flag is set.
- R10: The two channels are independent. A transition, clear or mode on one channel has no effect on the other channel's flag or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 2 | External pins, one per channel |
| globalEn | input | 1 | Processor global interrupt enable |
| ackIn | input | 2 | Per-channel service acknowledge, one cycle wide |
| regAddr | input | 2 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 4 | Register write data |
| regRdData | output | 4 | Register read data, combinational from regAddr |
| irqReq | output | 2 | Interrupt request, one per channel |

## Verification
The assertions assume that the acknowledge, enable and register inputs are synchronous to the clock and settled at each rising edge. Only the pins may be asynchronous, and they reach the checked logic only after the synchronizer. The stimulus changes every input a fixed time after the rising edge and holds it for at least one whole cycle. Each directed edge test holds the pin level for several cycles, so detection never depends on a pulse that is too short to be guaranteed. The collision tests place the clear in the exact cycle in which the synchronized transition appears.

// File: rtl/eint_pkg.sv
package eint_pkg;

  // Sense codes; encoding is visible to software at the mode register
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } senseE;

  // Strobes from the register decode to the datapath
  typedef struct packed {
    logic wrMode;
    logic wrMask;
    logic wrFlag;
    logic rdMode;
    logic rdMask;
    logic rdFlag;
  } regStrobeS;

  localparam int ADDR_MODE = 0;
  localparam int ADDR_MASK = 1;
  localparam int ADDR_FLAG = 2;

endpackage

// File: rtl/eint_control.sv
module eint_control
  import eint_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobeS         strobe
);

  logic hitMode;
  logic hitMask;
  logic hitFlag;

  assign hitMode = (regAddr == ADDR_W'(ADDR_MODE));
  assign hitMask = (regAddr == ADDR_W'(ADDR_MASK));
  assign hitFlag = (regAddr == ADDR_W'(ADDR_FLAG));

  always_comb begin
    strobe        = '0;
    strobe.rdMode = hitMode;
    strobe.rdMask = hitMask;
    strobe.rdFlag = hitFlag;
    strobe.wrMode = regWrEn & hitMode;
    strobe.wrMask = regWrEn & hitMask;
    strobe.wrFlag = regWrEn & hitFlag;
  end

  always_comb begin
    AST_ONE_READ_SEL: assert ($onehot0({strobe.rdMode, strobe.rdMask, strobe.rdFlag})); // R2
  end

endmodule

// File: rtl/eint_channel.sv
module eint_channel
  import eint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  pinIn,
  input  senseE mode,
  input  logic  maskBit,
  input  logic  globalEn,
  input  logic  clrReq,
  output logic  flagOut,
  output logic  reqOut
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic syncNow;
  logic prevQ;
  logic edgeHit;
  logic isLevel;
  logic flagQ;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], pinIn};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= pinIn;
      end
    end
  endgenerate

  assign syncNow = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncNow;
  end

  assign isLevel = (mode == SENSE_LOW);

  always_comb begin
    unique case (mode)
      SENSE_ANY:  edgeHit = syncNow ^ prevQ;
      SENSE_FALL: edgeHit = prevQ & ~syncNow;
      SENSE_RISE: edgeHit = ~prevQ & syncNow;
      default:    edgeHit = 1'b0;
    endcase
  end

  // Level mode keeps the flag empty; a new edge beats any clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        flagQ <= 1'b0;
    else if (isLevel) flagQ <= 1'b0;
    else if (edgeHit) flagQ <= 1'b1;
    else if (clrReq)  flagQ <= 1'b0;
  end

  assign flagOut = flagQ & ~isLevel;
  assign reqOut  = maskBit & globalEn & (isLevel ? ~syncNow : flagQ);

  AST_LEVEL_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    isLevel |=> !flagQ); // R7
  AST_LEVEL_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (isLevel && maskBit && globalEn && !syncNow) |-> reqOut); // R7
  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    reqOut |-> (maskBit && globalEn)); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (edgeHit && !isLevel) |=> flagQ); // R9
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && !edgeHit) |=> !flagQ); // R5
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!edgeHit && !clrReq && !isLevel) |=> (flagQ == $past(flagQ))); // R3
  AST_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(edgeHit)); // R3

endmodule

// File: rtl/eint_datapath.sv
module eint_datapath
  import eint_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobeS           strobe,
  input  logic [2*NUM_CH-1:0] regWrData,
  input  logic [NUM_CH-1:0]   pinIn,
  input  logic                globalEn,
  input  logic [NUM_CH-1:0]   ackIn,
  output logic [2*NUM_CH-1:0] regRdData,
  output logic [NUM_CH-1:0]   irqReq
);

  localparam int MODE_W = 2 * NUM_CH;

  logic [MODE_W-1:0] modeBits;
  logic [NUM_CH-1:0] maskReg;
  logic [NUM_CH-1:0] flagVec;
  logic [NUM_CH-1:0] clrVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeBits <= '0;
      maskReg  <= '0;
    end else begin
      if (strobe.wrMode) modeBits <= regWrData;
      if (strobe.wrMask) maskReg  <= regWrData[NUM_CH-1:0];
    end
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign clrVec[c] = (strobe.wrFlag & regWrData[c]) | ackIn[c];

      eint_channel #(
        .SYNC_STAGES(SYNC_STAGES)
      ) u_ch (
        .clk      (clk),
        .rstN     (rstN),
        .pinIn    (pinIn[c]),
        .mode     (senseE'(modeBits[2*c +: 2])),
        .maskBit  (maskReg[c]),
        .globalEn (globalEn),
        .clrReq   (clrVec[c]),
        .flagOut  (flagVec[c]),
        .reqOut   (irqReq[c])
      );
    end
  endgenerate

  always_comb begin
    regRdData = '0;
    if (strobe.rdMode) regRdData = modeBits;
    if (strobe.rdMask) regRdData[NUM_CH-1:0] = maskReg;
    if (strobe.rdFlag) regRdData[NUM_CH-1:0] = flagVec;
  end

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrMask |=> (maskReg == $past(regWrData[NUM_CH-1:0]))); // R2
  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrMode |=> $stable(modeBits)); // R2

endmodule

// File: rtl/eint_sense_top.sv
module eint_sense_top
  import eint_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CH-1:0]   pinIn,
  input  logic                globalEn,
  input  logic [NUM_CH-1:0]   ackIn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [2*NUM_CH-1:0] regWrData,
  output logic [2*NUM_CH-1:0] regRdData,
  output logic [NUM_CH-1:0]   irqReq
);

  regStrobeS strobe;

  eint_control #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe)
  );

  eint_datapath #(
    .NUM_CH      (NUM_CH),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regWrData (regWrData),
    .pinIn     (pinIn),
    .globalEn  (globalEn),
    .ackIn     (ackIn),
    .regRdData (regRdData),
    .irqReq    (irqReq)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (irqReq == '0)); // R1

endmodule

// File: tb/eint_sense_top_tb.sv
`timescale 1ns/100ps
module eint_sense_top_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] pinIn = 2'b00;
  logic       globalEn = 1'b0;
  logic [1:0] ackIn = 2'b00;
  logic [1:0] regAddr = 2'd2;
  logic       regWrEn = 1'b0;
  logic [3:0] regWrData = 4'h0;
  logic [3:0] regRdData;
  logic [1:0] irqReq;

  int    nRun = 0;
  int    nFail = 0;
  string phaseTag = "R1";
  bit    done = 1'b0;

  always #2 clk = ~clk;

  eint_sense_top u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .globalEn  (globalEn),
    .ackIn     (ackIn),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqReq    (irqReq)
  );

  // Behavioural reference: pin history queue, mode codes as integers
  int         mMode [2];
  bit [1:0]   mMask;
  bit [1:0]   mFlag;
  logic [1:0] hist [$];

  initial hist = '{2'b00, 2'b00, 2'b00};

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = '{0, 0};
      mMask = '0;
      mFlag = '0;
      hist  = '{2'b00, 2'b00, 2'b00};
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit now, old, hit, clr;
        now = hist[1][c];
        old = hist[2][c];
        hit = (mMode[c] == 1 && now != old) ||
              (mMode[c] == 2 && old && !now) ||
              (mMode[c] == 3 && !old && now);
        clr = (regWrEn && regAddr == 2'd2 && regWrData[c]) || ackIn[c];
        if (mMode[c] == 0) mFlag[c] = 1'b0;
        else if (hit)      mFlag[c] = 1'b1;
        else if (clr)      mFlag[c] = 1'b0;
      end
      if (regWrEn && regAddr == 2'd0) begin
        mMode[0] = int'(regWrData[1:0]);
        mMode[1] = int'(regWrData[3:2]);
      end
      if (regWrEn && regAddr == 2'd1) mMask = regWrData[1:0];
      hist.push_front(pinIn);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [1:0] expIrq;
      logic [3:0] expRd;
      for (int c = 0; c < 2; c++)
        expIrq[c] = globalEn & mMask[c] & ((mMode[c] == 0) ? ~hist[1][c] : mFlag[c]);
      case (regAddr)
        2'd0:    expRd = {2'(mMode[1]), 2'(mMode[0])};
        2'd1:    expRd = {2'b00, mMask};
        2'd2:    expRd = {2'b00, mFlag[1] & (mMode[1] != 0), mFlag[0] & (mMode[0] != 0)};
        default: expRd = 4'h0;
      endcase
      chk(irqReq === expIrq, {phaseTag, " irq"}, int'(irqReq), int'(expIrq));
      chk(regRdData === expRd, {phaseTag, " read"}, int'(regRdData), int'(expRd));
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    regWrEn   = 1'b1;
    regAddr   = a;
    regWrData = d;
    step();
    regWrEn = 1'b0;
    regAddr = 2'd2;
  endtask

  task automatic expectReg(input logic [1:0] a, input int exp, input string tag);
    regAddr = a;
    #0.5;
    chk(regRdData == 4'(exp), tag, int'(regRdData), exp);
    regAddr = 2'd2;
  endtask

  task automatic expectIrq(input int exp, input string tag);
    #0.5;
    chk(irqReq == 2'(exp), tag, int'(irqReq), exp);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step();
    phaseTag = "R1";
    expectReg(2'd0, 0, "R1 modes");
    expectReg(2'd1, 0, "R1 mask");
    expectReg(2'd2, 0, "R1 flags");
    expectIrq(0, "R1 irq");

    phaseTag = "R2";
    wr(2'd0, 4'b1110);                  // ch0 falling, ch1 rising
    expectReg(2'd0, 14, "R2 mode readback");
    wr(2'd1, 4'b0011);
    expectReg(2'd1, 3, "R2 mask readback");
    expectReg(2'd3, 0, "R2 unused address");

    phaseTag = "R3";
    globalEn = 1'b1;
    pinIn[0] = 1'b1; step(4);
    expectReg(2'd2, 0, "R3 rise ignored in falling mode");
    pinIn[0] = 1'b0; step(4);
    expectReg(2'd2, 1, "R3 falling edge sets flag");
    expectIrq(1, "R4 request from flag");
    phaseTag = "R10";
    pinIn[1] = 1'b1; step(4);
    expectReg(2'd2, 3, "R10 second channel independent");

    phaseTag = "R4";
    globalEn = 1'b0;
    expectIrq(0, "R4 global enable off");
    step();
    globalEn = 1'b1;
    wr(2'd1, 4'b0010);
    expectIrq(2, "R4 mask gates channel 0");
    wr(2'd1, 4'b0011);
    expectIrq(3, "R4 both enabled");

    phaseTag = "R5";
    wr(2'd2, 4'b0001);
    expectReg(2'd2, 2, "R5 write one clears");
    wr(2'd2, 4'b0000);
    expectReg(2'd2, 2, "R5 write zero keeps");

    phaseTag = "R6";
    ackIn = 2'b10; step(); ackIn = 2'b00;
    expectReg(2'd2, 0, "R6 acknowledge clears");

    phaseTag = "R3";
    wr(2'd0, 4'b1101);                  // ch0 any change
    pinIn[0] = 1'b1; step(4);
    expectReg(2'd2, 1, "R3 change mode rising");
    wr(2'd2, 4'b0001);
    pinIn[0] = 1'b0; step(4);
    expectReg(2'd2, 1, "R3 change mode falling");
    wr(2'd2, 4'b0001);

    phaseTag = "R7";
    wr(2'd0, 4'b1100);                  // ch0 low level
    expectReg(2'd2, 0, "R7 level flag reads zero");
    expectIrq(1, "R7 low pin requests");
    pinIn[0] = 1'b1; step(3);
    expectIrq(0, "R7 high pin drops request");
    pinIn[0] = 1'b0; step(2);
    expectIrq(1, "R7 request after sync delay");
    globalEn = 1'b0;
    expectIrq(0, "R7 level gated by enable");
    globalEn = 1'b1;

    phaseTag = "R8";
    pinIn[1] = 1'b0; step(4);
    wr(2'd2, 4'b0010);
    pinIn[1] = 1'b1; step(2);
    pinIn[1] = 1'b0; step(4);
    expectReg(2'd2, 2, "R8 two-cycle pulse detected");
    wr(2'd2, 4'b0010);
    pinIn[1] = 1'b1; step(2);
    expectReg(2'd2, 0, "R8 not yet visible after two edges");
    step();
    expectReg(2'd2, 2, "R8 visible on third edge");
    wr(2'd2, 4'b0010);

    phaseTag = "R9";
    pinIn[1] = 1'b0; step(4);
    pinIn[1] = 1'b1; step(2);
    regWrEn = 1'b1; regAddr = 2'd2; regWrData = 4'b0010;
    step();
    regWrEn = 1'b0;
    expectReg(2'd2, 2, "R9 edge beats write-one");
    wr(2'd2, 4'b0010);
    pinIn[1] = 1'b0; step(4);
    pinIn[1] = 1'b1; step(2);
    ackIn = 2'b10; step(); ackIn = 2'b00;
    expectReg(2'd2, 2, "R9 edge beats acknowledge");
    step(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      nRun++;
      nFail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule